// File: doc/BRIEF.md
# One-Level Section Translation Walker

This block turns a 32-bit virtual address into a physical address. It does this by fetching one descriptor from a table of 4096 word-sized entries held in memory. The table is 16 KB long and is aligned to 16 KB. Its location comes from a table-base input. The upper 12 bits of the virtual address select the entry. When the entry describes a 1 MB section, the section base from the entry replaces those upper 12 bits. The lower 20 bits pass through unchanged.

A requester presents an address on a valid/ready request port. The walker then issues exactly one word read on a valid/ready memory port and waits for the response. It decodes the response and presents the result for one cycle, with a valid pulse. The result holds the physical address, the domain number, the access-permission code and the two cacheability bits. A table entry that maps nothing is reported as a translation fault. Entries that point to second-level tables are reported as an unsupported-kind fault. Only one walk is in flight at a time. Permission checking and result caching belong to other blocks.

Top module: `sect_walker`

## Requirements
- R1: After reset, req_ready_o is 1, mem_rd_valid_o is 0, res_valid_o is 0, and every result output is 0.
- R2: The descriptor read address is {tbase_i[31:14], vaddr[31:20], 2'b00}, so bits 13:0 of the table base are ignored. While mem_rd_valid_o is high and mem_rd_ready_i is low, the request and its address stay unchanged.
- R3: For a section descriptor (bits 1:0 = 2'b10), res_paddr_o = {desc[31:20], vaddr[19:0]}.
- R4: For a section descriptor, res_domain_o = desc[8:5], res_ap_o = desc[11:10], res_cache_o = desc[3] (write-through) and res_buffer_o = desc[2] (write-back). Descriptor bits 4, 9 and 19:12 have no effect on any output.
- R5: A descriptor with bits 1:0 = 2'b00 sets res_xlate_fault_o. All other result outputs are then 0.
- R6: A descriptor with bits 1:0 = 2'b01 or 2'b11 sets res_unsup_fault_o. All other result outputs are then 0.
- R7: Each accepted request causes exactly one memory read. req_ready_o stays low from acceptance until the cycle after the result pulse. Requests presented while busy are not taken.
- R8: res_valid_o is high for exactly one cycle per walk. The result outputs keep their value until the next result.
- R9: The table base and the virtual address are sampled in the acceptance cycle. Changes on those inputs during a walk do not alter the fetch address or the result.
- R10: At most one of the two fault flags is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbase_i | input | 32 | Table base address (bits 31:14 used) |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept |
| req_vaddr_i | input | 32 | Virtual address to translate |
| mem_rd_valid_o | output | 1 | Descriptor read request valid |
| mem_rd_ready_i | input | 1 | Memory accepts the read request |
| mem_rd_addr_o | output | 32 | Descriptor byte address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Returned descriptor word |
| res_valid_o | output | 1 | One-cycle result pulse |
| res_paddr_o | output | 32 | Translated physical address |
| res_domain_o | output | 4 | Domain number of the section |
| res_ap_o | output | 2 | Access-permission code |
| res_cache_o | output | 1 | Write-through attribute bit |
| res_buffer_o | output | 1 | Write-back attribute bit |
| res_xlate_fault_o | output | 1 | Entry maps nothing |
| res_unsup_fault_o | output | 1 | Entry is a second-level table kind |

## Verification
The bench checks index and offset values at both extremes: entry 0, entry 0xFFF, offset 0xFFFFF and section base 0xFFF. A walker that sliced the wrong bits would then return a shifted address or read the wrong entry. It also gives a table base with its low 14 bits set, and a descriptor with every unused bit set. A design that let either one leak would show wrong fetch addresses or wrong attributes. Memory stalls and response delays are varied, and requests are left asserted during a walk. A walker that fetched twice, or picked up the base or address after acceptance, would show an extra read or a changed result. All four descriptor kinds are applied. A design that decoded coarse or fine entries as sections, or left stale fields beside a fault flag, would fail the zero-field checks.

// File: rtl/sw_pkg.sv
// Shared definitions for the section walker: walk states, descriptor kind
// codes and descriptor field positions. Assumes 32-bit descriptors.
package sw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } walk_state_e;

    typedef enum logic [1:0] {
        KIND_FAULT   = 2'b00,
        KIND_COARSE  = 2'b01,
        KIND_SECTION = 2'b10,
        KIND_FINE    = 2'b11
    } desc_kind_e;

    localparam int KIND_LSB    = 0;
    localparam int B_POS       = 2;
    localparam int C_POS       = 3;
    localparam int RSVD_LO_POS = 4;
    localparam int DOM_LSB     = 5;
    localparam int DOM_W       = 4;
    localparam int RSVD_HI_POS = 9;
    localparam int AP_LSB      = 10;
    localparam int AP_W        = 2;

endpackage

// File: rtl/sw_fetch_addr.sv
// Descriptor address generator: keeps the table base above the table size
// and inserts the word index taken from the top of the virtual address.
// Assumes the table is aligned to its own size (entries x 4 bytes).
module sw_fetch_addr #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 12
) (
    input  logic [ADDR_W-1:0] tbase_i,
    input  logic [ADDR_W-1:0] vaddr_i,
    output logic [ADDR_W-1:0] fetch_o
);
    localparam int OFF_W   = ADDR_W - IDX_W;
    localparam int TBL_LSB = IDX_W + 2;

    logic unused_tbase_low;

    // Concatenate aligned base, entry index and byte-in-word zeros
    assign fetch_o = {tbase_i[ADDR_W-1:TBL_LSB], vaddr_i[ADDR_W-1:OFF_W], 2'b00};

    // Low base bits and the offset are deliberately not used here
    assign unused_tbase_low = ^{tbase_i[TBL_LSB-1:0], vaddr_i[OFF_W-1:0]};

endmodule

// File: rtl/sw_desc_decode.sv
// Descriptor decoder: classifies one descriptor word by its kind bits and,
// for a section, forms the physical address and extracts the attributes.
// Any fault zeroes every field except its own flag.
module sw_desc_decode
    import sw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 12
) (
    input  logic [ADDR_W-1:0]       desc_i,
    input  logic [ADDR_W-IDX_W-1:0] off_i,
    output logic [ADDR_W-1:0]       paddr_o,
    output logic [DOM_W-1:0]        domain_o,
    output logic [AP_W-1:0]         ap_o,
    output logic                    cache_o,
    output logic                    buffer_o,
    output logic                    xlate_fault_o,
    output logic                    unsup_fault_o
);
    localparam int OFF_W = ADDR_W - IDX_W;

    desc_kind_e kind;
    logic       unused_desc_bits;

    // Kind code sits in the two lowest descriptor bits
    assign kind = desc_kind_e'(desc_i[KIND_LSB +: 2]);

    // Bits with no meaning for a section are ignored
    assign unused_desc_bits = ^{desc_i[RSVD_LO_POS], desc_i[RSVD_HI_POS],
                                desc_i[OFF_W-1:AP_LSB+AP_W]};

    // Decode fields per descriptor kind
    always_comb begin
        paddr_o       = '0;
        domain_o      = '0;
        ap_o          = '0;
        cache_o       = 1'b0;
        buffer_o      = 1'b0;
        xlate_fault_o = 1'b0;
        unsup_fault_o = 1'b0;
        unique case (kind)
            KIND_SECTION: begin
                paddr_o  = {desc_i[ADDR_W-1:OFF_W], off_i};
                domain_o = desc_i[DOM_LSB +: DOM_W];
                ap_o     = desc_i[AP_LSB +: AP_W];
                cache_o  = desc_i[C_POS];
                buffer_o = desc_i[B_POS];
            end
            KIND_FAULT: xlate_fault_o = 1'b1;
            default:    unsup_fault_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/sw_walk_fsm.sv
// Walk sequencer: idle -> issue read -> wait data -> present result -> idle.
// Assumes the memory returns exactly one response per accepted read.
module sw_walk_fsm
    import sw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid_i,
    input  logic mem_rd_ready_i,
    input  logic mem_rsp_valid_i,
    output logic req_ready_o,
    output logic mem_rd_valid_o,
    output logic capture_req_o,
    output logic capture_rsp_o,
    output logic res_valid_o
);
    walk_state_e state_q;
    walk_state_e state_d;

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid_i)     state_d = ST_ISSUE;
            ST_ISSUE: if (mem_rd_ready_i)  state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid_i) state_d = ST_DONE;
            ST_DONE:                       state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // Handshake and load strobes decoded from state
    assign req_ready_o    = (state_q == ST_IDLE);
    assign mem_rd_valid_o = (state_q == ST_ISSUE);
    assign res_valid_o    = (state_q == ST_DONE);
    assign capture_req_o  = (state_q == ST_IDLE) && req_valid_i;
    assign capture_rsp_o  = (state_q == ST_WAIT) && mem_rsp_valid_i;

endmodule

// File: rtl/sect_walker.sv
// Section translation walker top. Samples base and address on acceptance,
// performs one descriptor read, decodes it and registers the result, which
// holds until the next walk completes. One walk in flight at a time.
module sect_walker
    import sw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] tbase_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ADDR_W-1:0] req_vaddr_i,
    output logic              mem_rd_valid_o,
    input  logic              mem_rd_ready_i,
    output logic [ADDR_W-1:0] mem_rd_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [ADDR_W-1:0] mem_rsp_data_i,
    output logic              res_valid_o,
    output logic [ADDR_W-1:0] res_paddr_o,
    output logic [DOM_W-1:0]  res_domain_o,
    output logic [AP_W-1:0]   res_ap_o,
    output logic              res_cache_o,
    output logic              res_buffer_o,
    output logic              res_xlate_fault_o,
    output logic              res_unsup_fault_o
);
    localparam int OFF_W = ADDR_W - IDX_W;

    logic              capture_req;
    logic              capture_rsp;
    logic [ADDR_W-1:0] fetch_d;
    logic [ADDR_W-1:0] fetch_q;
    logic [OFF_W-1:0]  off_q;

    logic [ADDR_W-1:0] dec_paddr;
    logic [DOM_W-1:0]  dec_domain;
    logic [AP_W-1:0]   dec_ap;
    logic              dec_cache;
    logic              dec_buffer;
    logic              dec_xf;
    logic              dec_uf;

    sw_walk_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid_i    (req_valid_i),
        .mem_rd_ready_i (mem_rd_ready_i),
        .mem_rsp_valid_i(mem_rsp_valid_i),
        .req_ready_o    (req_ready_o),
        .mem_rd_valid_o (mem_rd_valid_o),
        .capture_req_o  (capture_req),
        .capture_rsp_o  (capture_rsp),
        .res_valid_o    (res_valid_o)
    );

    sw_fetch_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fetch (
        .tbase_i(tbase_i),
        .vaddr_i(req_vaddr_i),
        .fetch_o(fetch_d)
    );

    sw_desc_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .desc_i       (mem_rsp_data_i),
        .off_i        (off_q),
        .paddr_o      (dec_paddr),
        .domain_o     (dec_domain),
        .ap_o         (dec_ap),
        .cache_o      (dec_cache),
        .buffer_o     (dec_buffer),
        .xlate_fault_o(dec_xf),
        .unsup_fault_o(dec_uf)
    );

    // Capture fetch address and page offset when a request is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_q <= '0;
            off_q   <= '0;
        end else if (capture_req) begin
            fetch_q <= fetch_d;
            off_q   <= req_vaddr_i[OFF_W-1:0];
        end
    end

    // Register the decoded result when the descriptor arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_paddr_o       <= '0;
            res_domain_o      <= '0;
            res_ap_o          <= '0;
            res_cache_o       <= 1'b0;
            res_buffer_o      <= 1'b0;
            res_xlate_fault_o <= 1'b0;
            res_unsup_fault_o <= 1'b0;
        end else if (capture_rsp) begin
            res_paddr_o       <= dec_paddr;
            res_domain_o      <= dec_domain;
            res_ap_o          <= dec_ap;
            res_cache_o       <= dec_cache;
            res_buffer_o      <= dec_buffer;
            res_xlate_fault_o <= dec_xf;
            res_unsup_fault_o <= dec_uf;
        end
    end

    assign mem_rd_addr_o = fetch_q;

endmodule

// File: rtl/sect_walker_chk.sv
// Protocol and result checker for sect_walker, attached by bind.
module sect_walker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic              mem_rd_valid_o,
    input logic              mem_rd_ready_i,
    input logic [ADDR_W-1:0] mem_rd_addr_o,
    input logic              res_valid_o,
    input logic [ADDR_W-1:0] res_paddr_o,
    input logic              res_xlate_fault_o,
    input logic              res_unsup_fault_o
);
    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid_o && !mem_rd_ready_i |=> mem_rd_valid_o && $stable(mem_rd_addr_o));

    // R7
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid_o |-> !req_ready_o);

    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && req_ready_o |=> !req_ready_o && mem_rd_valid_o);

    // R8
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    // R8
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o |-> $stable(res_paddr_o));

    // R10
    one_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_xlate_fault_o, res_unsup_fault_o}));

    // R5
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o && (res_xlate_fault_o || res_unsup_fault_o) |-> res_paddr_o == '0);

endmodule

bind sect_walker sect_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid_i      (req_valid_i),
    .req_ready_o      (req_ready_o),
    .mem_rd_valid_o   (mem_rd_valid_o),
    .mem_rd_ready_i   (mem_rd_ready_i),
    .mem_rd_addr_o    (mem_rd_addr_o),
    .res_valid_o      (res_valid_o),
    .res_paddr_o      (res_paddr_o),
    .res_xlate_fault_o(res_xlate_fault_o),
    .res_unsup_fault_o(res_unsup_fault_o)
);

// File: tb/sect_walker_tb.sv
module sect_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tbase = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        res_valid;
    logic [31:0] res_paddr;
    logic [3:0]  res_domain;
    logic [1:0]  res_ap;
    logic        res_cache, res_buffer, res_xf, res_uf;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // memory model configuration and observation
    int          stall_cfg = 0;
    int          lat_cfg   = 0;
    logic [31:0] rsp_desc  = '0;
    int          wait_cnt;
    int          lat_left;
    logic        pend;
    int          rd_count;
    logic [31:0] last_rd_addr;

    always #5 clk = ~clk;

    sect_walker u_dut (
        .clk(clk), .rst_n(rst_n), .tbase_i(tbase),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
        .mem_rd_valid_o(mem_rd_valid), .mem_rd_ready_i(mem_rd_ready),
        .mem_rd_addr_o(mem_rd_addr), .mem_rsp_valid_i(mem_rsp_valid),
        .mem_rsp_data_i(mem_rsp_data), .res_valid_o(res_valid),
        .res_paddr_o(res_paddr), .res_domain_o(res_domain), .res_ap_o(res_ap),
        .res_cache_o(res_cache), .res_buffer_o(res_buffer),
        .res_xlate_fault_o(res_xf), .res_unsup_fault_o(res_uf)
    );

    assign mem_rd_ready = (wait_cnt >= stall_cfg);

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (!rst_n) begin
            wait_cnt     <= 0;
            pend         <= 1'b0;
            lat_left     <= 0;
            rd_count     <= 0;
            last_rd_addr <= '0;
            mem_rsp_data <= '0;
        end else begin
            if (pend) begin
                if (lat_left == 0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= rsp_desc;
                    pend          <= 1'b0;
                end else begin
                    lat_left <= lat_left - 1;
                end
            end
            if (mem_rd_valid) begin
                if (mem_rd_ready) begin
                    wait_cnt     <= 0;
                    pend         <= 1'b1;
                    lat_left     <= lat_cfg;
                    rd_count     <= rd_count + 1;
                    last_rd_addr <= mem_rd_addr;
                end else begin
                    wait_cnt <= wait_cnt + 1;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [31:0] tbase;
        logic [31:0] vaddr;
        logic [31:0] desc;
        logic [31:0] fetch;
        logic [31:0] paddr;
        logic [3:0]  dom;
        logic [1:0]  ap;
        logic        c;
        logic        b;
        logic        xf;
        logic        uf;
        logic [1:0]  stall;
        logic [1:0]  lat;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        // identity section, entry 768
        '{32'h0000_4000, 32'h3000_0012, 32'h3000_0C0E, 32'h0000_4C00, 32'h3000_0012,
          4'd0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0},
        // last entry, domain 9, stalled memory
        '{32'h8001_C000, 32'hFFF8_ABCD, 32'h1230_0526, 32'h8001_FFFC, 32'h1238_ABCD,
          4'd9, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 2'd1},
        // fault entry 0
        '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
          4'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 2'd3},
        // coarse kind
        '{32'h0000_8000, 32'h0010_0005, 32'hABCD_E5E1, 32'h0000_8004, 32'h0000_0000,
          4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd2},
        // fine kind
        '{32'hFFFF_C000, 32'h7FF0_0000, 32'h7FF0_0FFF, 32'hFFFF_DFFC, 32'h0000_0000,
          4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 2'd0},
        // base low bits set, unused descriptor bits set, max offset
        '{32'h1234_7FFF, 32'h5A5F_FFFF, 32'h000F_FBFA, 32'h1234_5694, 32'h000F_FFFF,
          4'd15, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 2'd1},
        // top section base
        '{32'h0000_0000, 32'h0000_0001, 32'hFFF0_0002, 32'h0000_0000, 32'hFFF0_0001,
          4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0}
    };

    task automatic launch(input logic [31:0] tb, input logic [31:0] va,
                          input logic [31:0] d, input int st, input int lt);
        @(negedge clk);
        stall_cfg = st;
        lat_cfg   = lt;
        rsp_desc  = d;
        tbase     = tb;
        req_vaddr = va;
        req_valid = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_result();
        while (!res_valid) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int rc0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
        chk("R1 mem_rd_valid", {31'd0, mem_rd_valid}, 32'd0);
        chk("R1 res_valid", {31'd0, res_valid}, 32'd0);
        chk("R1 res_paddr", res_paddr, 32'd0);
        chk("R1 fault flags", {30'd0, res_xf, res_uf}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            launch(VECS[i].tbase, VECS[i].vaddr, VECS[i].desc,
                   int'(VECS[i].stall), int'(VECS[i].lat));
            req_valid = 1'b0;
            wait_result();
            chk("R2 fetch address", last_rd_addr, VECS[i].fetch);
            chk("R3 physical address", res_paddr, VECS[i].paddr);
            chk("R4 domain", {28'd0, res_domain}, {28'd0, VECS[i].dom});
            chk("R4 ap", {30'd0, res_ap}, {30'd0, VECS[i].ap});
            chk("R4 cache/buffer", {30'd0, res_cache, res_buffer},
                {30'd0, VECS[i].c, VECS[i].b});
            chk("R5 xlate fault", {31'd0, res_xf}, {31'd0, VECS[i].xf});
            chk("R6 unsup fault", {31'd0, res_uf}, {31'd0, VECS[i].uf});
            chk("R10 single flag", {31'd0, res_xf & res_uf}, 32'd0);
            @(negedge clk);
        end

        // R7 / R9: request held and inputs changed during a walk
        rc0 = rd_count;
        launch(32'h0000_4000, 32'h3000_0012, 32'h3000_0C0E, 3, 2);
        tbase     = 32'hFFFF_C000;
        req_vaddr = 32'h0010_0000;
        chk("R7 ready low while busy", {31'd0, req_ready}, 32'd0);
        wait_result();
        chk("R9 fetch from sampled base", last_rd_addr, 32'h0000_4C00);
        chk("R9 result from sampled address", res_paddr, 32'h3000_0012);
        chk("R7 ready low in result cycle", {31'd0, req_ready}, 32'd0);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R8 pulse one cycle", {31'd0, res_valid}, 32'd0);
        chk("R7 ready after result", {31'd0, req_ready}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R7 one read per walk", rd_count - rc0, 32'd1);
        chk("R8 result held", res_paddr, 32'h3000_0012);
        chk("R8 no extra pulse", {31'd0, res_valid}, 32'd0);

        // R8: a fault after a section replaces the held result
        launch(32'h0000_0000, 32'h0020_0000, 32'h0000_0000, 0, 0);
        req_valid = 1'b0;
        wait_result();
        chk("R5 fault clears address", res_paddr, 32'd0);
        chk("R5 fault clears attributes",
            {26'd0, res_domain, res_cache, res_buffer}, 32'd0);
        chk("R2 entry 2 fetch", last_rd_addr, 32'h0000_0008);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule